// File: doc/BRIEF.md
# UART Transmit Byte Queue

This block is the transmit-side byte buffer of a UART. Software writes a word to the transmit data register, and the block stores the low byte of that word. The serializer takes bytes out through a ready/valid pop port. Bytes leave only while the transmit enable bit is set. The block keeps the fill level and derives the full and empty status bits from it. It also produces three interrupt events: a watermark event, a drained event and an overflow event.

The watermark threshold comes from a field of the FIFO control register. The same register holds a flush bit. A control write with the flush bit set empties the queue in one cycle. The level is reported through a narrow status field, and that field is the level truncated to the field width.

Top module: `uart_txq`

## Requirements
- R1: A push stores bits [7:0] of `wr_word_i`. `pop_data_o` always presents the oldest stored byte, so bytes leave in the order they were written.
- R2: A push while the level equals DEPTH (32) is dropped and leaves the contents unchanged. In that case `overflow_o` pulses high for the one cycle after the push.
- R3: `full_o` is 1 exactly when the level equals DEPTH. It drops in the cycle after any pop that leaves the queue non-full.
- R4: `empty_o` is 1 exactly when the level is zero. `drained_o` pulses for one cycle in the cycle after the level goes from non-zero to zero.
- R5: The threshold in effect is the value written in the same cycle by a control write, or the stored value otherwise. `wmark_o` is cleared whenever the next level is below that threshold. It is set after an accepted push that leaves the level at or above it. Otherwise it holds.
- R6: A control write with `ctl_flush_i`=1 empties the queue, clears `wmark_o` and takes priority over a push or pop in the same cycle. `drained_o` follows if the queue was not empty.
- R7: `level_o` is the low 5 bits of the level, so a full queue reads 0 with `full_o`=1.
- R8: `pop_valid_o` is high only when `tx_en_i`=1 and the queue is not empty. A byte is removed only on `pop_valid_o` and `pop_ready_i` together.
- R9: An accepted push and a pop in the same cycle leave the level unchanged.
- R10: After reset the level is 0, `empty_o`=1, `full_o`=0, the threshold is 0 and all events are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_push_i | input | 1 | Write strobe of the transmit data register |
| wr_word_i | input | 32 | Written word; only bits [7:0] are stored |
| ctl_wr_i | input | 1 | Write strobe of the FIFO control register |
| ctl_flush_i | input | 1 | Flush bit of the written control value |
| ctl_thresh_i | input | 6 | Watermark threshold field of the written control value |
| tx_en_i | input | 1 | Transmit enable bit of the control register |
| pop_ready_i | input | 1 | Serializer accepts a byte |
| pop_valid_o | output | 1 | A byte is offered to the serializer |
| pop_data_o | output | 8 | Oldest byte |
| full_o | output | 1 | Full status bit |
| empty_o | output | 1 | Empty status bit |
| level_o | output | 5 | Level field for the FIFO status register |
| wmark_o | output | 1 | Watermark interrupt event |
| drained_o | output | 1 | Drained interrupt event pulse |
| overflow_o | output | 1 | Dropped-push event pulse |

## Verification
The assertions check the cycle-level invariants continuously:
- the level never exceeds the depth;
- a flush always leaves the queue empty;
- a push into a full queue with no pop leaves it full;
- the level cannot fall while transmit is disabled;
- a raised watermark implies the level is at or above the threshold;
- a drained pulse coincides with an empty queue.

Byte ordering, the truncated level field, the exact cycle of each event pulse, and the priority of a flush over a concurrent push only show up when the bench compares the outputs against its reference queue. The bench does this in directed fill, overflow, drain and flush scenarios and in a long random run.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

   typedef struct packed {
      logic ovf;
      logic drained;
      logic wmark;
   } txq_evt_t;

endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_adv_i,
   input  logic              flush_i,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q, wp_inc, rp_inc;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_inc = wp_q + 1'b1;
         assign rp_inc = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_inc = (wp_q == LAST) ? '0 : wp_q + 1'b1;
         assign rp_inc = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q <= '0;
         rp_q <= '0;
      end else if (flush_i) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (wr_en_i)  wp_q <= wp_inc;
         if (rd_adv_i) rp_q <= rp_inc;
      end
   end

   always_ff @(posedge clk_i) begin
      if (wr_en_i && !flush_i) mem_q[wp_q] <= wr_data_i;
   end

   assign rd_data_o = mem_q[rp_q];

endmodule

// File: rtl/uart_txq_level.sv
module uart_txq_level #(
   parameter int DEPTH = 32,
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             flush_i,
   output logic [CNT_W-1:0] lvl_o,
   output logic [CNT_W-1:0] lvl_nxt_o
);
   logic [CNT_W-1:0] lvl_q, lvl_d;

   always_comb begin
      lvl_d = lvl_q;
      if (flush_i)              lvl_d = '0;
      else if (push_i && !pop_i) lvl_d = lvl_q + 1'b1;
      else if (pop_i && !push_i) lvl_d = lvl_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= '0;
      else         lvl_q <= lvl_d;
   end

   assign lvl_o     = lvl_q;
   assign lvl_nxt_o = lvl_d;

   // R3: level bounded by the depth
   a_r3_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_q <= CNT_W'(DEPTH));

   // R6: flush empties the queue
   a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> lvl_q == '0);

endmodule

// File: rtl/uart_txq_evt.sv
module uart_txq_evt
   import uart_txq_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] lvl_i,
   input  logic [CNT_W-1:0] lvl_nxt_i,
   input  logic             push_req_i,
   input  logic             push_acc_i,
   input  logic             flush_i,
   input  logic             ctl_wr_i,
   input  logic [CNT_W-1:0] thr_i,
   output txq_evt_t         evt_o
);
   logic [CNT_W-1:0] thr_q, thr_eff;
   txq_evt_t         evt_q, evt_d;

   assign thr_eff = ctl_wr_i ? thr_i : thr_q;

   always_comb begin
      evt_d.ovf     = push_req_i && !push_acc_i && !flush_i;
      evt_d.drained = (lvl_i != '0) && (lvl_nxt_i == '0);
      evt_d.wmark   = evt_q.wmark;
      if (flush_i)                 evt_d.wmark = 1'b0;
      else if (lvl_nxt_i < thr_eff) evt_d.wmark = 1'b0;
      else if (push_acc_i)          evt_d.wmark = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_q <= '0;
         evt_q <= '0;
      end else begin
         thr_q <= thr_eff;
         evt_q <= evt_d;
      end
   end

   assign evt_o = evt_q;

   // R5: a raised watermark implies the level meets the threshold
   a_r5_wmark_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q.wmark |-> lvl_i >= thr_q);

   // R4: drained pulse only with an empty queue
   a_r4_drained_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q.drained |-> lvl_i == '0);

endmodule

// File: rtl/uart_txq.sv
module uart_txq
   import uart_txq_pkg::*;
#(
   parameter int DEPTH       = 32,
   parameter int DATA_W      = 8,
   parameter int WORD_W      = 32,
   parameter int LVL_FIELD_W = 5
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_push_i,
   input  logic [WORD_W-1:0]             wr_word_i,
   input  logic                          ctl_wr_i,
   input  logic                          ctl_flush_i,
   input  logic [$clog2(DEPTH+1)-1:0]    ctl_thresh_i,
   input  logic                          tx_en_i,
   input  logic                          pop_ready_i,
   output logic                          pop_valid_o,
   output logic [DATA_W-1:0]             pop_data_o,
   output logic                          full_o,
   output logic                          empty_o,
   output logic [LVL_FIELD_W-1:0]        level_o,
   output logic                          wmark_o,
   output logic                          drained_o,
   output logic                          overflow_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_txq: DEPTH must be at least 2");
      end
      if (WORD_W < DATA_W) begin : g_bad_word
         $error("uart_txq: WORD_W must cover DATA_W");
      end
      if (LVL_FIELD_W > CNT_W) begin : g_bad_field
         $error("uart_txq: LVL_FIELD_W wider than the level counter");
      end
   endgenerate

   logic             flush, push_acc, pop_acc;
   logic [CNT_W-1:0] lvl, lvl_nxt;
   txq_evt_t         evt;

   assign flush       = ctl_wr_i && ctl_flush_i;
   assign full_o      = (lvl == CNT_W'(DEPTH));
   assign empty_o     = (lvl == '0);
   assign push_acc    = wr_push_i && !flush && !full_o;
   assign pop_valid_o = tx_en_i && !empty_o;
   assign pop_acc     = pop_valid_o && pop_ready_i && !flush;

   generate
      if (WORD_W > DATA_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^wr_word_i[WORD_W-1:DATA_W];
      end
   endgenerate

   uart_txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (push_acc),
      .wr_data_i (wr_word_i[DATA_W-1:0]),
      .rd_adv_i  (pop_acc),
      .flush_i   (flush),
      .rd_data_o (pop_data_o)
   );

   uart_txq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_level (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (push_acc),
      .pop_i     (pop_acc),
      .flush_i   (flush),
      .lvl_o     (lvl),
      .lvl_nxt_o (lvl_nxt)
   );

   uart_txq_evt #(.CNT_W(CNT_W)) i_evt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (lvl),
      .lvl_nxt_i  (lvl_nxt),
      .push_req_i (wr_push_i),
      .push_acc_i (push_acc),
      .flush_i    (flush),
      .ctl_wr_i   (ctl_wr_i),
      .thr_i      (ctl_thresh_i),
      .evt_o      (evt)
   );

   assign level_o    = lvl[LVL_FIELD_W-1:0];
   assign wmark_o    = evt.wmark;
   assign drained_o  = evt.drained;
   assign overflow_o = evt.ovf;

   // R2: a push into a full queue without a pop leaves it full
   a_r2_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_push_i && full_o && !pop_acc && !flush) |=> full_o);

   // R8: nothing leaves while transmit is disabled
   a_r8_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tx_en_i && !flush) |=> lvl >= $past(lvl));

endmodule

// File: tb/test_uart_txq.sv
module test_uart_txq;
   localparam int DEPTH = 32;
   localparam time CLK_P = 4ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_push = 1'b0, ctl_wr = 1'b0, ctl_flush = 1'b0, tx_en = 1'b0, pop_ready = 1'b0;
   logic [31:0] wr_word = '0;
   logic [5:0]  ctl_thresh = '0;
   logic pop_valid, full, empty, wmark, drained, overflow;
   logic [7:0] pop_data;
   logic [4:0] level;

   int n_vec = 0, n_bad = 0;
   byte unsigned q[$];
   bit wm_m = 0, dr_m = 0, ov_m = 0;
   int thr_m = 0;

   always #(CLK_P/2) clk = ~clk;

   uart_txq i_uart_txq (
      .clk_i(clk), .rst_ni(rst_n), .wr_push_i(wr_push), .wr_word_i(wr_word),
      .ctl_wr_i(ctl_wr), .ctl_flush_i(ctl_flush), .ctl_thresh_i(ctl_thresh),
      .tx_en_i(tx_en), .pop_ready_i(pop_ready), .pop_valid_o(pop_valid),
      .pop_data_o(pop_data), .full_o(full), .empty_o(empty), .level_o(level),
      .wmark_o(wmark), .drained_o(drained), .overflow_o(overflow));

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit wm_next(bit cur, bit fl, int nl, bit acc, int thr);
      if (fl) return 0;
      if (nl < thr) return 0;
      if (acc) return 1;
      return cur;
   endfunction

   task automatic check_regs();
      chk("R7 level field", level, q.size() & 31);
      chk("R3 full", full, q.size() == DEPTH);
      chk("R4 empty", empty, q.size() == 0);
      chk("R4 drained", drained, dr_m);
      chk("R5 watermark", wmark, wm_m);
      chk("R2 overflow", overflow, ov_m);
   endtask

   task automatic step(input bit push, input logic [31:0] word, input bit rdy, input bit en,
                       input bit cw, input bit fl, input int thr);
      bit exp_v, fe, popd, acc;
      int old;
      @(negedge clk);
      wr_push = push; wr_word = word; pop_ready = rdy; tx_en = en;
      ctl_wr = cw; ctl_flush = fl; ctl_thresh = 6'(thr);
      #1;
      exp_v = en && q.size() != 0;
      chk("R8 pop valid", pop_valid, exp_v);
      if (exp_v) chk("R1 pop data", pop_data, q[0]);
      fe   = cw && fl;
      old  = q.size();
      popd = exp_v && rdy && !fe;
      acc  = push && !fe && old != DEPTH;
      ov_m = push && !fe && old == DEPTH;
      if (fe) q.delete();
      else begin
         if (popd) void'(q.pop_front());
         if (acc) q.push_back(word[7:0]);
      end
      dr_m = old != 0 && q.size() == 0;
      if (cw) thr_m = thr;
      wm_m = wm_next(wm_m, fe, q.size(), acc, thr_m);
      @(posedge clk);
      #1;
      wr_push = 0; ctl_wr = 0; ctl_flush = 0; pop_ready = 0;
      check_regs();
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      chk("R10 empty", empty, 1); chk("R10 full", full, 0);
      chk("R10 level", level, 0); chk("R10 wmark", wmark, 0);
      chk("R10 valid", pop_valid, 0);
      rst_n = 1'b1;
      step(0, 0, 0, 0, 1, 0, 4);
      for (int i = 0; i < DEPTH; i++) step(1, 32'hAB00 | 32'((i * 7 + 3) & 255), 0, 0, 0, 0, thr_m);
      chk("R7 full reads zero", level, 0); chk("R3 full set", full, 1);
      chk("R5 wmark at full", wmark, 1);
      step(1, 32'h55, 0, 0, 0, 0, thr_m);
      chk("R2 overflow pulse", overflow, 1);
      chk("R2 level kept", full, 1);
      step(1, 32'h66, 1, 1, 0, 0, thr_m);
      chk("R3 full cleared", full, 0);
      step(1, 32'h77, 1, 1, 0, 0, thr_m);
      chk("R9 push and pop", level, 31);
      for (int i = 0; i < 31; i++) step(0, 0, 1, 1, 0, 0, thr_m);
      chk("R4 drained pulse", drained, 1); chk("R5 wmark off", wmark, 0);
      for (int i = 0; i < 3; i++) step(1, 32'(i + 9), 0, 1, 0, 0, thr_m);
      step(0, 0, 1, 0, 0, 0, thr_m);
      chk("R8 disabled holds", level, 3);
      step(1, 32'h99, 1, 1, 1, 1, 2);
      chk("R6 flush level", level, 0); chk("R6 flush drained", drained, 1);
      chk("R6 flush wmark", wmark, 0);
      for (int i = 0; i < 4000; i++) begin
         bit cw;
         cw = ($urandom_range(31) == 0);
         step(bit'($urandom_range(1)), $urandom, bit'($urandom_range(1)),
              $urandom_range(7) != 0, cw, cw && ($urandom_range(3) == 0),
              cw ? int'($urandom_range(40)) : thr_m);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule